// File: doc/BRIEF.md
# Acquisition Pacer and Burst Timing Engine

This block times the conversions of an analog-input channel. A down-counter of up to 24 bits sets the scan rate, and a 10-bit down-counter spaces the conversions inside one scan. A third counter of 16 bits counts issued conversions and flags each time a programmed number of them has gone by. Select inputs route the triggers. The pacer is started by software or by an external trigger. A burst (scan) is started by a pacer tick or by an external trigger. The conversion strobe comes from a software pulse, from every pacer tick, or from every burst step.

Every counter is programmed with its divisor minus one. A programmed value of zero is treated as one, so the smallest divisor is 2. Counters reload from their programmed value on terminal count. The transfer counter has two modes. It can raise an event and let acquisition continue, or it can halt acquisition at its terminal count. A full result FIFO also halts conversions. A halt lasts until the next pacer start. Trigger inputs arrive already synchronised and one cycle wide.

Top module: `acq_pacer_engine`

## Requirements
- R1: After reset, `conv_strobe`, `about_event`, `halted` and `pacer_running` are all 0.
- R2: With `pace_start_src` = 0 (software), a `sw_start_rd` pulse starts the pacer. With `pace_start_src` = 1 (external), `sw_start_rd` is ignored and an `ext_pace_trig` pulse starts the pacer.
- R3: With `pace_stop_src` = 0, a `sw_stop_wr` pulse stops the pacer from the next cycle on, and no further pacer-driven strobes follow. With `pace_stop_src` = 1, `sw_stop_wr` has no effect.
- R4: With `conv_src` = 1 (pacer), a running pacer issues one `conv_strobe` every `pace_div_m1`+1 cycles.
- R5: A programmed value of 0 in any counter acts as 1, giving a divisor of 2. For example, `pace_div_m1` = 0 gives a strobe every 2 cycles.
- R6: With `conv_src` = 2 (burst) and `burst_start_src` = 1 (pacer), each pacer tick starts a scan of `scan_len_m1`+1 strobes spaced `burst_div_m1`+1 cycles apart. Scans start `pace_div_m1`+1 cycles apart.
- R7: With `burst_start_src` = 2 (external), `ext_burst_trig` starts a scan. A trigger that arrives while a scan is in progress is ignored. The values 0 and 3 start no scan.
- R8: With `conv_src` = 0 (software), each `sw_conv` pulse gives exactly one `conv_strobe` on the next cycle. Pacer ticks then cause no strobes.
- R9: `about_event` pulses together with every (`about_div_m1`+1)-th strobe after a pacer start. With `about_stop_en` = 1, acquisition continues afterwards.
- R10: With `about_stop_en` = 0, the terminal strobe of the transfer counter sets `halted` and clears `pacer_running`, and no further strobes follow.
- R11: No strobe follows a cycle in which `fifo_full` is high. While the pacer runs, `fifo_full` sets `halted`. `halted` stays set after `fifo_full` falls, until the next pacer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| pace_div_m1 | input | 24 | Pacer divisor minus one |
| burst_div_m1 | input | 10 | Burst divisor minus one |
| about_div_m1 | input | 16 | Conversions per transfer event, minus one |
| scan_len_m1 | input | 8 | Conversions per scan, minus one |
| conv_src | input | 2 | Strobe source: 0 software, 1 pacer, 2 burst |
| pace_start_src | input | 1 | Pacer start: 0 software, 1 external |
| pace_stop_src | input | 1 | 0: software write stops the pacer; 1: write ignored |
| burst_start_src | input | 2 | Scan start: 1 pacer tick, 2 external, others none |
| about_stop_en | input | 1 | 1: event only; 0: halt on terminal count |
| sw_start_rd | input | 1 | Software read of the pacer control, one cycle |
| sw_stop_wr | input | 1 | Software write of the pacer control, one cycle |
| sw_conv | input | 1 | Software conversion request, one cycle |
| ext_pace_trig | input | 1 | Conditioned external pacer start |
| ext_burst_trig | input | 1 | Conditioned external scan start |
| fifo_full | input | 1 | Result FIFO full |
| conv_strobe | output | 1 | One-cycle conversion strobe |
| about_event | output | 1 | One-cycle transfer-threshold event |
| halted | output | 1 | Acquisition halted by full FIFO or transfer counter |
| pacer_running | output | 1 | Pacer is counting |

## Verification
The assertions check on every cycle that a strobe never follows a full-FIFO cycle and that a transfer event only appears together with a strobe. They also check that a halted engine never shows a running pacer, that a software-sourced strobe always follows a software request, and that an enabled stop write always leaves the pacer stopped. Only the bench scenarios can show the spacing of strobes: pacer periods, the divisor clamp, the gaps inside a scan and between scans, and the number of strobes per scan. The same holds for the count of strobes before an event or a halt, and for how each trigger source starts or fails to start activity.

// File: rtl/acq_timing_pkg.sv
package acq_timing_pkg;

    typedef enum logic [1:0] {
        CONV_SW    = 2'd0,
        CONV_PACER = 2'd1,
        CONV_BURST = 2'd2
    } conv_src_e;

    typedef enum logic {
        PSTART_SW  = 1'b0,
        PSTART_EXT = 1'b1
    } pstart_e;

    typedef enum logic {
        PSTOP_SW   = 1'b0,
        PSTOP_HOLD = 1'b1
    } pstop_e;

    typedef enum logic [1:0] {
        BSTART_NONE  = 2'd0,
        BSTART_PACER = 2'd1,
        BSTART_EXT   = 2'd2,
        BSTART_OFF   = 2'd3
    } bstart_e;

    typedef struct packed {
        logic run;
        logic halted;
    } run_state_t;

endpackage

// File: rtl/acq_down_counter.sv
module acq_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_full,
    input  logic         load_zero,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic         at_zero
);
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    // divisor below 2 is not allowed: a programmed 0 acts as 1
    assign eff     = (reload_val == '0) ? W'(1) : reload_val;
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_full)
            cnt <= eff;
        else if (load_zero)
            cnt <= '0;
        else if (step)
            cnt <= (cnt == '0) ? eff : cnt - 1'b1;
    end
endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl
    import acq_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       halt_evt,
    output run_state_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (halt_evt) begin
            state.run    <= 1'b0;
            state.halted <= 1'b1;
        end else if (start_evt) begin
            state.run    <= 1'b1;
            state.halted <= 1'b0;
        end else if (stop_evt) begin
            state.run    <= 1'b0;
        end
    end
endmodule

// File: rtl/acq_burst_seq.sv
module acq_burst_seq #(
    parameter int SCAN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trigger,
    input  logic              abort,
    input  logic              bc_zero,
    input  logic [SCAN_W-1:0] scan_len_m1,
    output logic              accept,
    output logic              active,
    output logic              fire
);
    logic [SCAN_W-1:0] remain;

    assign accept = trigger & ~active & ~abort;
    assign fire   = active & bc_zero & ~abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (abort) begin
            active <= 1'b0;
        end else if (accept) begin
            active <= 1'b1;
            remain <= scan_len_m1;
        end else if (fire) begin
            if (remain == '0)
                active <= 1'b0;
            else
                remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/acq_pacer_engine.sv
module acq_pacer_engine
    import acq_timing_pkg::*;
#(
    parameter int PACE_W  = 24,
    parameter int BURST_W = 10,
    parameter int ABOUT_W = 16,
    parameter int SCAN_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PACE_W-1:0]  pace_div_m1,
    input  logic [BURST_W-1:0] burst_div_m1,
    input  logic [ABOUT_W-1:0] about_div_m1,
    input  logic [SCAN_W-1:0]  scan_len_m1,
    input  logic [1:0]         conv_src,
    input  logic               pace_start_src,
    input  logic               pace_stop_src,
    input  logic [1:0]         burst_start_src,
    input  logic               about_stop_en,
    input  logic               sw_start_rd,
    input  logic               sw_stop_wr,
    input  logic               sw_conv,
    input  logic               ext_pace_trig,
    input  logic               ext_burst_trig,
    input  logic               fifo_full,
    output logic               conv_strobe,
    output logic               about_event,
    output logic               halted,
    output logic               pacer_running
);
    conv_src_e  csel;
    pstart_e    psel;
    pstop_e     ssel;
    bstart_e    bsel;
    run_state_t st;

    logic start_evt, stop_evt, halt_evt;
    logic pace_zero, pace_tick;
    logic burst_trig, burst_accept, burst_active, burst_fire, burst_zero;
    logic about_zero, about_tc;
    logic conv_req, conv_fire;

    assign csel = conv_src_e'(conv_src);
    assign psel = pstart_e'(pace_start_src);
    assign ssel = pstop_e'(pace_stop_src);
    assign bsel = bstart_e'(burst_start_src);

    always_comb begin
        start_evt = (psel == PSTART_SW) ? sw_start_rd : (ext_pace_trig & ~st.run);
        stop_evt  = sw_stop_wr & (ssel == PSTOP_SW);
        pace_tick = st.run & pace_zero;
        unique case (bsel)
            BSTART_PACER: burst_trig = pace_tick;
            BSTART_EXT:   burst_trig = ext_burst_trig;
            default:      burst_trig = 1'b0;
        endcase
        unique case (csel)
            CONV_SW:    conv_req = sw_conv;
            CONV_PACER: conv_req = pace_tick;
            CONV_BURST: conv_req = burst_fire;
            default:    conv_req = 1'b0;
        endcase
        conv_fire = conv_req & ~st.halted & ~fifo_full;
        about_tc  = conv_fire & about_zero;
        halt_evt  = (fifo_full & st.run) | (about_tc & ~about_stop_en);
    end

    acq_run_ctrl u_run (
        .clk       (clk),
        .rst       (rst),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .halt_evt  (halt_evt),
        .state     (st)
    );

    acq_down_counter #(.W(PACE_W)) u_pace_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_full  (start_evt),
        .load_zero  (1'b0),
        .step       (st.run),
        .reload_val (pace_div_m1),
        .at_zero    (pace_zero)
    );

    acq_down_counter #(.W(BURST_W)) u_burst_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_full  (1'b0),
        .load_zero  (burst_accept),
        .step       (burst_active),
        .reload_val (burst_div_m1),
        .at_zero    (burst_zero)
    );

    acq_burst_seq #(.SCAN_W(SCAN_W)) u_burst_seq (
        .clk         (clk),
        .rst         (rst),
        .trigger     (burst_trig),
        .abort       (st.halted),
        .bc_zero     (burst_zero),
        .scan_len_m1 (scan_len_m1),
        .accept      (burst_accept),
        .active      (burst_active),
        .fire        (burst_fire)
    );

    acq_down_counter #(.W(ABOUT_W)) u_about_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_full  (start_evt),
        .load_zero  (1'b0),
        .step       (conv_fire),
        .reload_val (about_div_m1),
        .at_zero    (about_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_strobe <= 1'b0;
            about_event <= 1'b0;
        end else begin
            conv_strobe <= conv_fire;
            about_event <= about_tc;
        end
    end

    assign halted        = st.halted;
    assign pacer_running = st.run;
endmodule

// File: rtl/acq_pacer_engine_chk.sv
module acq_pacer_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_strobe,
    input logic       about_event,
    input logic       halted,
    input logic       pacer_running,
    input logic       fifo_full,
    input logic       sw_conv,
    input logic [1:0] conv_src,
    input logic       sw_stop_wr,
    input logic       sw_start_rd,
    input logic       ext_pace_trig,
    input logic       pace_stop_src
);
    assert_no_strobe_after_full_R11: assert property (@(posedge clk) disable iff (rst)
        conv_strobe |-> !$past(fifo_full));

    assert_event_with_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        about_event |-> conv_strobe);

    assert_halt_stops_pacer_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !pacer_running);

    assert_sw_strobe_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (conv_strobe && $past(conv_src) == 2'd0) |-> $past(sw_conv));

    assert_stop_write_R3: assert property (@(posedge clk) disable iff (rst)
        (sw_stop_wr && !pace_stop_src && !sw_start_rd && !ext_pace_trig) |=> !pacer_running);
endmodule

bind acq_pacer_engine acq_pacer_engine_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .conv_strobe   (conv_strobe),
    .about_event   (about_event),
    .halted        (halted),
    .pacer_running (pacer_running),
    .fifo_full     (fifo_full),
    .sw_conv       (sw_conv),
    .conv_src      (conv_src),
    .sw_stop_wr    (sw_stop_wr),
    .sw_start_rd   (sw_start_rd),
    .ext_pace_trig (ext_pace_trig),
    .pace_stop_src (pace_stop_src)
);

// File: tb/test_acq_pacer_engine.sv
`timescale 1ns/1ps
module test_acq_pacer_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pace_div_m1 = '0;
    logic [9:0]  burst_div_m1 = '0;
    logic [15:0] about_div_m1 = 16'hFFFF;
    logic [7:0]  scan_len_m1 = '0;
    logic [1:0]  conv_src = 2'd1;
    logic        pace_start_src = 1'b0;
    logic        pace_stop_src = 1'b0;
    logic [1:0]  burst_start_src = 2'd0;
    logic        about_stop_en = 1'b1;
    logic        sw_start_rd = 1'b0, sw_stop_wr = 1'b0, sw_conv = 1'b0;
    logic        ext_pace_trig = 1'b0, ext_burst_trig = 1'b0, fifo_full = 1'b0;
    logic        conv_strobe, about_event, halted, pacer_running;

    int checks = 0, errors = 0, cyc = 0, nstr = 0, nev = 0;
    int st[64];
    int ev[16];
    bit done = 1'b0;

    always #2 clk = ~clk;

    acq_pacer_engine i_acq_pacer_engine (.*);

    always @(negedge clk) begin
        cyc++;
        if (conv_strobe) begin
            if (nstr < 64) st[nstr] = cyc;
            nstr++;
        end
        if (about_event) begin
            if (nev < 16) ev[nev] = cyc;
            nev++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1;
        nstr = 0; nev = 0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(); sw_start_rd = 1; @(negedge clk); sw_start_rd = 0; endtask
    task automatic pulse_stop();  sw_stop_wr = 1;  @(negedge clk); sw_stop_wr = 0;  endtask

    task automatic check_gaps(input string tag, input int gap);
        for (int i = 1; i < nstr && i < 64; i++)
            chk(st[i] - st[i-1] == gap, tag, st[i] - st[i-1], gap);
    endtask

    task automatic t_reset();
        chk(conv_strobe == 0 && about_event == 0, "R1 strobe/event", int'(conv_strobe), 0);
        chk(halted == 0 && pacer_running == 0, "R1 halted/running", int'(halted), 0);
    endtask

    task automatic t_pacer();
        conv_src = 2'd1; pace_div_m1 = 24'd9;
        clear_log();
        pulse_start();
        chk(pacer_running == 1, "R2 software start", int'(pacer_running), 1);
        wait_cyc(65);
        chk(nstr >= 6, "R4 strobe count", nstr, 6);
        check_gaps("R4 pacer period", 10);
        pulse_stop();
        chk(pacer_running == 0, "R3 stop write", int'(pacer_running), 0);
        wait_cyc(2);
        clear_log();
        wait_cyc(40);
        chk(nstr == 0, "R3 no strobes after stop", nstr, 0);
    endtask

    task automatic t_clamp();
        conv_src = 2'd1; pace_div_m1 = 24'd0;
        clear_log();
        pulse_start();
        wait_cyc(20);
        chk(nstr >= 8, "R5 strobe count", nstr, 8);
        check_gaps("R5 clamped period", 2);
        pulse_stop(); wait_cyc(3);
    endtask

    task automatic t_burst_pacer();
        conv_src = 2'd2; burst_start_src = 2'd1;
        pace_div_m1 = 24'd49; burst_div_m1 = 10'd3; scan_len_m1 = 8'd3;
        clear_log();
        pulse_start();
        wait_cyc(130);
        chk(nstr == 8, "R6 strobes in two scans", nstr, 8);
        if (nstr == 8) begin
            chk(st[1] - st[0] == 4, "R6 in-scan gap", st[1] - st[0], 4);
            chk(st[3] - st[2] == 4, "R6 in-scan gap", st[3] - st[2], 4);
            chk(st[4] - st[0] == 50, "R6 scan period", st[4] - st[0], 50);
            chk(st[7] - st[4] == 12, "R6 second scan span", st[7] - st[4], 12);
        end
        pulse_stop(); wait_cyc(20);
    endtask

    task automatic t_burst_ext();
        conv_src = 2'd2; burst_start_src = 2'd2;
        burst_div_m1 = 10'd2; scan_len_m1 = 8'd2;
        clear_log();
        ext_burst_trig = 1; @(negedge clk); ext_burst_trig = 0;
        wait_cyc(3);
        ext_burst_trig = 1; @(negedge clk); ext_burst_trig = 0;
        wait_cyc(30);
        chk(nstr == 3, "R7 one scan, retrigger ignored", nstr, 3);
        check_gaps("R7 external scan gap", 3);
        burst_start_src = 2'd3;
        clear_log();
        ext_burst_trig = 1; @(negedge clk); ext_burst_trig = 0;
        wait_cyc(20);
        chk(nstr == 0, "R7 start source 3 starts nothing", nstr, 0);
    endtask

    task automatic t_sw_conv();
        conv_src = 2'd0; pace_div_m1 = 24'd4;
        pulse_start();
        clear_log();
        for (int i = 0; i < 3; i++) begin
            sw_conv = 1; @(negedge clk); sw_conv = 0;
            wait_cyc(4);
        end
        wait_cyc(10);
        chk(nstr == 3, "R8 one strobe per request", nstr, 3);
        check_gaps("R8 software spacing", 5);
        pulse_stop(); wait_cyc(3);
    endtask

    task automatic t_ext_start_and_hold();
        conv_src = 2'd1; pace_div_m1 = 24'd4; pace_start_src = 1;
        pulse_start(); wait_cyc(2);
        chk(pacer_running == 0, "R2 software start ignored", int'(pacer_running), 0);
        clear_log();
        ext_pace_trig = 1; @(negedge clk); ext_pace_trig = 0;
        chk(pacer_running == 1, "R2 external start", int'(pacer_running), 1);
        wait_cyc(30);
        chk(nstr >= 5, "R2 strobes after external start", nstr, 5);
        pace_stop_src = 1;
        pulse_stop(); wait_cyc(2);
        chk(pacer_running == 1, "R3 stop write ignored", int'(pacer_running), 1);
        pace_stop_src = 0; pace_start_src = 0;
        pulse_stop(); wait_cyc(3);
    endtask

    task automatic t_about();
        conv_src = 2'd1; pace_div_m1 = 24'd3; about_div_m1 = 16'd2; about_stop_en = 1;
        clear_log();
        pulse_start();
        wait_cyc(60);
        chk(nstr >= 12, "R9 acquisition continues", nstr, 12);
        chk(nev == nstr / 3, "R9 event count", nev, nstr / 3);
        if (nev > 0 && nstr > 2) chk(ev[0] == st[2], "R9 event on third strobe", ev[0], st[2]);
        chk(halted == 0, "R9 not halted", int'(halted), 0);
        pulse_stop(); wait_cyc(3);
        about_stop_en = 0;
        clear_log();
        pulse_start();
        wait_cyc(60);
        chk(nstr == 3, "R10 strobes before halt", nstr, 3);
        chk(nev == 1, "R10 single event", nev, 1);
        chk(halted == 1, "R10 halted", int'(halted), 1);
        chk(pacer_running == 0, "R10 pacer stopped", int'(pacer_running), 0);
        about_stop_en = 1; about_div_m1 = 16'hFFFF;
    endtask

    task automatic t_fifo_full();
        conv_src = 2'd1; pace_div_m1 = 24'd3;
        pulse_start();
        chk(halted == 0, "R11 start clears halt", int'(halted), 0);
        wait_cyc(20);
        fifo_full = 1;
        wait_cyc(2);
        clear_log();
        wait_cyc(20);
        chk(nstr == 0, "R11 no strobes while full", nstr, 0);
        chk(halted == 1, "R11 halted on full", int'(halted), 1);
        fifo_full = 0;
        clear_log();
        wait_cyc(20);
        chk(nstr == 0, "R11 halt persists", nstr, 0);
        chk(halted == 1, "R11 halt persists flag", int'(halted), 1);
        pulse_start();
        wait_cyc(20);
        chk(nstr > 0, "R11 restart resumes", nstr, 1);
        pulse_stop(); wait_cyc(3);
    endtask

    initial begin
        wait_cyc(4);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_pacer();
        t_clamp();
        t_burst_pacer();
        t_burst_ext();
        t_sw_conv();
        t_ext_start_and_hold();
        t_about();
        t_fifo_full();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule